// File: doc/BRIEF.md
# Clock Frequency Range Monitor

This block watches a monitored clock and checks its rate against a reference clock. The reference clock also runs the register port. A window timer in the reference domain counts a programmable number of reference cycles. At the start and at the end of each window the block takes a snapshot of a free-running edge counter in the monitored domain. Each snapshot crosses between the domains through a toggle request/acknowledge handshake. The difference between two snapshots is the number of monitored rising edges in the window.

In range mode, each window count is compared with a software-programmed upper limit and lower limit. A count above the upper limit sets a sticky high flag and a count below the lower limit sets a sticky low flag. If a window closes while the handshake is still outstanding, the monitored clock is taken to be absent and the count is 0. The two flags drive two separate fault lines to a fault collector. These fault lines ignore the interrupt enables. The interrupt output is gated per flag.

In measure mode the block runs one window and stores the raw edge count. It then sets a done flag and disables itself. From the window length and the count, software derives the period ratio it needs to trim an oscillator.

Top module: `clk_range_mon`

## Requirements
- R1: After reset the monitor is disabled, every register reads 0, and `flag_high`, `flag_low`, `irq`, `fault_high` and `fault_low` are all 0.
- R2: In range mode (CTRL at address 0, bit 0 enable = 1, bit 1 mode = 0), a window count greater than the upper limit (address 2) sets the high flag. The high flag is STATUS bit 0 at address 4 and also drives `flag_high`.
- R3: In range mode, a window count less than the lower limit (address 3) sets the low flag. The low flag is STATUS bit 1 and also drives `flag_low`.
- R4: In range mode, a window count between the lower limit and the upper limit, both inclusive, sets neither flag.
- R5: If a window of the length in address 1 ends before the monitored clock answers the snapshot handshake, the count is 0 and the low flag is set, even when the lower limit is 0.
- R6: Both flags are sticky. Writing 1 to STATUS bit 0 clears the high flag and writing 1 to bit 1 clears the low flag. Writing 0 to a bit leaves that flag unchanged.
- R7: `irq` is high when the high flag is set and CTRL bit 2 is 1, or when the low flag is set and CTRL bit 3 is 1. Otherwise `irq` is low.
- R8: `fault_high` follows the high flag and `fault_low` follows the low flag, whatever the interrupt enables are set to.
- R9: In measure mode (CTRL bit 1 = 1), one window is run. Its edge count is stored in RESULT (address 5), STATUS bit 2 (done) is set, and CTRL bit 0 returns to 0. Neither range flag changes.
- R10: In range mode, RESULT holds the edge count of the latest finished window. This count is the number of monitored rising edges in that many reference cycles, within ±3.
- R11: While CTRL bit 0 is 0, no flag is set, whatever the limits are and whatever the monitored clock is doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also clocks the register port |
| rst_n | input | 1 | Active-low asynchronous reset for both clock domains |
| mon_clk | input | 1 | Monitored clock |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | CW | Register write data |
| reg_rdata | output | CW | Register read data for `reg_addr` (combinational) |
| flag_high | output | 1 | Sticky frequency-high flag |
| flag_low | output | 1 | Sticky frequency-low or missing-clock flag |
| irq | output | 1 | Interrupt: the flags gated by their enables |
| fault_high | output | 1 | Fault line to the collector for the high event |
| fault_low | output | 1 | Fault line to the collector for the low event |

## Verification
The range check runs from a table of monitored-clock periods and limit pairs. The set covers a count inside the limits, one above them and one below them, and a pair in which the same clock passes one limit set but fails another. Together these show that the comparison uses the programmed limits rather than any fixed threshold. Directed cases follow. One stops the monitored clock to separate a missing clock from a slow one. One toggles the interrupt enables while a flag stays set, which separates `irq` from the fault lines. One runs measure mode with limits that would flag, which shows that measurement leaves the flags alone. One keeps the block disabled, which shows that nothing is judged without the enable.

// File: rtl/crm_pkg.sv
package crm_pkg;

    typedef enum logic [2:0] {
        REG_CTRL = 3'd0,
        REG_WIN  = 3'd1,
        REG_HI   = 3'd2,
        REG_LO   = 3'd3,
        REG_STAT = 3'd4,
        REG_RES  = 3'd5
    } crm_reg_e;

    localparam int CTRL_EN   = 0;
    localparam int CTRL_MODE = 1;
    localparam int CTRL_IEH  = 2;
    localparam int CTRL_IEL  = 3;

    localparam int STAT_HI   = 0;
    localparam int STAT_LO   = 1;
    localparam int STAT_DONE = 2;

endpackage

// File: rtl/crm_sync.sv
module crm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/crm_mon_side.sv
module crm_mon_side #(
    parameter int CW   = 16,
    parameter int SYNC = 2
) (
    input  logic          mon_clk,
    input  logic          rst_n,
    input  logic          req_tgl,
    output logic          ack_tgl,
    output logic [CW-1:0] hold
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] hold;
        logic          ack;
    } mon_st_t;

    mon_st_t d, q;
    logic    req_s;

    crm_sync #(.STAGES(SYNC)) u_req_sync (
        .clk(mon_clk), .rst_n(rst_n), .d(req_tgl), .q(req_s)
    );

    always_comb begin
        d     = q;
        d.cnt = q.cnt + 1'b1;
        if (req_s != q.ack) begin
            d.hold = q.cnt;
            d.ack  = req_s;
        end
    end

    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ack_tgl = q.ack;
    assign hold    = q.hold;
endmodule

// File: rtl/crm_window.sv
module crm_window #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] win,
    output logic          tick
);
    localparam int TW = CW + 1;

    logic [CW-1:0] tmr_d, tmr_q;
    logic [TW-1:0] nxt;

    always_comb begin
        nxt  = {1'b0, tmr_q} + TW'(1);
        tick = run && (nxt >= {1'b0, win});
        if (!run || tick) tmr_d = '0;
        else              tmr_d = tmr_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/clk_range_mon.sv
module clk_range_mon
    import crm_pkg::*;
#(
    parameter int CW   = 16,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mon_clk,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [CW-1:0] reg_wdata,
    output logic [CW-1:0] reg_rdata,
    output logic          flag_high,
    output logic          flag_low,
    output logic          irq,
    output logic          fault_high,
    output logic          fault_low
);
    localparam int PAD_CTRL = CW - 4;
    localparam int PAD_STAT = CW - 3;

    typedef struct packed {
        logic          en;
        logic          mode;
        logic          ie_hi;
        logic          ie_lo;
        logic [CW-1:0] win;
        logic [CW-1:0] lim_hi;
        logic [CW-1:0] lim_lo;
        logic          fl_hi;
        logic          fl_lo;
        logic          done;
        logic [CW-1:0] result;
        logic [CW-1:0] base;
        logic          req;
        logic          pend;
        logic          base_next;
    } st_t;

    st_t d, q;

    logic          ack_raw, ack_s, tick;
    logic [CW-1:0] mon_hold;
    logic          ack_done, eval_vld;
    logic [CW-1:0] eval_cnt;
    logic          en_w, done_w;

    crm_mon_side #(.CW(CW), .SYNC(SYNC)) u_mon (
        .mon_clk(mon_clk), .rst_n(rst_n), .req_tgl(q.req),
        .ack_tgl(ack_raw), .hold(mon_hold)
    );

    crm_sync #(.STAGES(SYNC)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .d(ack_raw), .q(ack_s)
    );

    crm_window #(.CW(CW)) u_win (
        .clk(clk), .rst_n(rst_n), .run(q.en), .win(q.win), .tick(tick)
    );

    always_comb begin
        d        = q;
        ack_done = q.pend && (ack_s == q.req);
        eval_vld = 1'b0;
        eval_cnt = '0;

        if (reg_we) begin
            case (reg_addr)
                REG_CTRL: begin
                    d.en    = reg_wdata[CTRL_EN];
                    d.mode  = reg_wdata[CTRL_MODE];
                    d.ie_hi = reg_wdata[CTRL_IEH];
                    d.ie_lo = reg_wdata[CTRL_IEL];
                    if (reg_wdata[CTRL_EN] && !q.en) begin
                        d.base_next = 1'b1;
                        if (!q.pend) begin
                            d.req  = ~q.req;
                            d.pend = 1'b1;
                        end
                    end
                end
                REG_WIN:  d.win    = reg_wdata;
                REG_HI:   d.lim_hi = reg_wdata;
                REG_LO:   d.lim_lo = reg_wdata;
                REG_STAT: begin
                    if (reg_wdata[STAT_HI])   d.fl_hi = 1'b0;
                    if (reg_wdata[STAT_LO])   d.fl_lo = 1'b0;
                    if (reg_wdata[STAT_DONE]) d.done  = 1'b0;
                end
                default: ;
            endcase
        end

        // snapshot returned from the monitored domain
        if (ack_done) begin
            d.pend = 1'b0;
            d.base = mon_hold;
            if (q.base_next) begin
                d.base_next = 1'b0;
            end else begin
                eval_vld = 1'b1;
                eval_cnt = mon_hold - q.base;
            end
        end

        // window end: either request the closing snapshot or declare a miss
        if (tick) begin
            if (q.pend && !ack_done) begin
                eval_vld    = 1'b1;
                eval_cnt    = '0;
                d.base_next = 1'b1;
            end else begin
                d.req  = ~q.req;
                d.pend = 1'b1;
            end
        end

        if (eval_vld && q.en) begin
            d.result = eval_cnt;
            if (q.mode) begin
                d.done = 1'b1;
                d.en   = 1'b0;
            end else begin
                if (eval_cnt == '0 || eval_cnt < q.lim_lo) d.fl_lo = 1'b1;
                if (eval_cnt > q.lim_hi)                    d.fl_hi = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (reg_addr)
            REG_CTRL: reg_rdata = {{PAD_CTRL{1'b0}}, q.ie_lo, q.ie_hi, q.mode, q.en};
            REG_WIN:  reg_rdata = q.win;
            REG_HI:   reg_rdata = q.lim_hi;
            REG_LO:   reg_rdata = q.lim_lo;
            REG_STAT: reg_rdata = {{PAD_STAT{1'b0}}, q.done, q.fl_lo, q.fl_hi};
            REG_RES:  reg_rdata = q.result;
            default:  reg_rdata = '0;
        endcase
    end

    assign flag_high  = q.fl_hi;
    assign flag_low   = q.fl_lo;
    assign fault_high = q.fl_hi;
    assign fault_low  = q.fl_lo;
    assign irq        = (q.fl_hi & q.ie_hi) | (q.fl_lo & q.ie_lo);
    assign en_w       = q.en;
    assign done_w     = q.done;
endmodule

// File: rtl/crm_chk.sv
module crm_chk (
    input logic clk,
    input logic rst_n,
    input logic clr_hi,
    input logic clr_lo,
    input logic flag_high,
    input logic flag_low,
    input logic irq,
    input logic en,
    input logic done
);
    AST_STICKY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_high && !clr_hi) |=> flag_high);                       // R6
    AST_STICKY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_low && !clr_lo) |=> flag_low);                         // R6
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_high || flag_low));                            // R7
    AST_HIGH_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_high) |-> $past(en));                             // R11
    AST_LOW_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_low) |-> $past(en));                              // R11
    AST_MEASURE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !en);                                        // R9
endmodule

bind clk_range_mon crm_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_hi    (reg_we && reg_addr == 3'd4 && reg_wdata[0]),
    .clr_lo    (reg_we && reg_addr == 3'd4 && reg_wdata[1]),
    .flag_high (flag_high),
    .flag_low  (flag_low),
    .irq       (irq),
    .en        (en_w),
    .done      (done_w)
);

// File: tb/clk_range_mon_tb_top.sv
`timescale 1ns/1ps
module clk_range_mon_tb_top;
    localparam int CW  = 16;
    localparam int WIN = 100;

    typedef struct packed {
        int half;
        int lo;
        int hi;
        bit eh;
        bit el;
        int cnt;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{5,  190, 210, 1'b0, 1'b0, 200},
        '{4,  190, 210, 1'b1, 1'b0, 250},
        '{10, 190, 210, 1'b0, 1'b1, 100},
        '{5,  100, 150, 1'b1, 1'b0, 200},
        '{20, 40,  60,  1'b0, 1'b0, 50},
        '{20, 60,  400, 1'b0, 1'b1, 50}
    };

    logic          clk = 0, rst_n = 0, mon_clk = 0;
    logic          reg_we = 0;
    logic [2:0]    reg_addr = 0;
    logic [CW-1:0] reg_wdata = 0;
    logic [CW-1:0] reg_rdata;
    logic          flag_high, flag_low, irq, fault_high, fault_low;
    int            mon_half = 5;
    bit            mon_run = 1;
    int            checks = 0, fails = 0;

    clk_range_mon #(.CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .mon_clk(mon_clk),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .flag_high(flag_high), .flag_low(flag_low),
        .irq(irq), .fault_high(fault_high), .fault_low(fault_low)
    );

    always #10 clk = ~clk;

    initial forever begin
        #(mon_half * 1ns);
        if (mon_run) mon_clk = ~mon_clk;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_near(input string tag, input int act, input int exp, input int tol);
        checks++;
        if (act < exp - tol || act > exp + tol) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d+-%0d", tag, act, exp, tol);
        end
    endtask

    task automatic wr(input logic [2:0] a, input int v);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = CW'(v);
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiesce();
        wr(3'd0, 0);
        wait_cyc(20);
        wr(3'd4, 7);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int v;
        wait_cyc(5);
        // R1: reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            check("R1 register reads zero", v, 0);
        end
        check("R1 outputs quiet", {flag_high, flag_low, irq, fault_high, fault_low}, 0);
        rst_n = 1;
        wait_cyc(3);
        rd(3'd0, v);
        check("R1 disabled after reset", v & 1, 0);

        wr(3'd1, WIN);

        // Table walk: R2 R3 R4 R8 R10
        for (int i = 0; i < 6; i++) begin
            mon_half = VECS[i].half;
            wr(3'd3, VECS[i].lo);
            wr(3'd2, VECS[i].hi);
            wait_cyc(10);
            wr(3'd4, 7);
            wr(3'd0, 1);
            wait_cyc(4 * WIN + 20);
            rd(3'd4, v);
            check("R2 high flag per limits", v & 1, int'(VECS[i].eh));
            check("R3 R4 low flag per limits", (v >> 1) & 1, int'(VECS[i].el));
            check("R8 fault lines follow flags", {fault_high, fault_low}, {VECS[i].eh, VECS[i].el});
            check("R7 irq low with enables off", irq, 0);
            rd(3'd5, v);
            check_near("R10 result edge count", v, VECS[i].cnt, 3);
            quiesce();
        end

        // R7 R8: high flag with interrupt enables
        mon_half = 4;
        wr(3'd3, 190); wr(3'd2, 210);
        wr(3'd0, 32'h5);
        wait_cyc(3 * WIN);
        check("R7 irq with high enable", irq, 1);
        wr(3'd0, 32'h1);
        check("R7 irq masked", irq, 0);
        check("R8 fault_high with irq masked", fault_high, 1);
        wr(3'd0, 32'h9);
        check("R7 low enable ignores high flag", irq, 0);
        wr(3'd0, 0);
        wait_cyc(20);

        // R6: sticky, write-one-to-clear
        wr(3'd4, 0);
        check("R6 write zero keeps high", flag_high, 1);
        wr(3'd4, 2);
        check("R6 clearing low keeps high", flag_high, 1);
        wr(3'd4, 1);
        check("R6 write one clears high", flag_high, 0);
        quiesce();

        // R5: missing monitored clock
        mon_run = 0;
        wr(3'd3, 0); wr(3'd2, 1000);
        wr(3'd0, 1);
        wait_cyc(2 * WIN + 20);
        check("R5 missing clock sets low", flag_low, 1);
        check("R5 missing clock no high", flag_high, 0);
        rd(3'd5, v);
        check("R5 result zero", v, 0);
        wr(3'd0, 0);
        mon_run = 1;
        wait_cyc(40);
        wr(3'd4, 7);
        wait_cyc(5);

        // R9: measure mode with limits that would flag in range mode
        mon_half = 5;
        wr(3'd3, 300); wr(3'd2, 400);
        wait_cyc(10);
        wr(3'd0, 3);
        wait_cyc(WIN + 40);
        rd(3'd4, v);
        check("R9 done set", (v >> 2) & 1, 1);
        check("R9 flags untouched", v & 3, 0);
        rd(3'd0, v);
        check("R9 enable self-clears", v & 1, 0);
        rd(3'd5, v);
        check_near("R9 measured count", v, 200, 3);
        wr(3'd4, 4);
        rd(3'd4, v);
        check("R9 done clears", v, 0);

        // R11: disabled monitor never flags
        mon_half = 4;
        wr(3'd3, 500); wr(3'd2, 10);
        wait_cyc(4 * WIN);
        rd(3'd4, v);
        check("R11 no flags while disabled", v, 0);
        check("R11 fault lines quiet", {fault_high, fault_low}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule